// File: doc/BRIEF.md
# Dual-Lane Register File with Port Self-Test

This block holds an eight-entry, 32-bit register file shared by two issue lanes. Each lane owns one write port and two read ports, so the storage has two write decoders and four read multiplexers. In normal operation the functional address, data and enable inputs reach the storage unchanged. A built-in test sequencer can take those ports over to check that the storage cells, every write decoder and every read multiplexer work.

A one-cycle start pulse launches the test. The registers are split into two groups, and within each group any two indices differ in at least two bits. One group receives an alternating-ones pattern and the other receives its complement. Both lanes write in parallel, each lane to its own half of each group. After an idle gap, every register is read through the first read port of both lanes and then through the second. Each value read is added into a 32-bit signature. The lanes then swap halves and repeat. The whole run is then repeated with the two patterns exchanged. At the end the signature is compared with an expected value supplied by the integrator, and a done pulse is raised together with the pass or fail result.

Top module: `regfile_bist`

## Requirements
- R1: After reset the busy, done and fail outputs are 0, the signature is 0, and all eight registers read 0 on every read port.
- R2: When no test is running, an enabled write on either lane stores its data at its address at the clock edge. Each of the four read ports returns, without a clock edge, the register its address selects.
- R3: When both lanes write the same register in the same cycle, the value from lane B is kept.
- R4: A start pulse while idle raises busy at the next edge. Busy stays high for exactly 92 cycles, made of four phases of 4 write cycles, 3 idle cycles and 16 read cycles. Done is high for exactly the one cycle in which busy has just fallen.
- R5: The signature starts at 0 and is the 32-bit wrapping sum of every value read during the test. Pattern P is 32'h5555_5555 and Q is 32'hAAAA_AAAA. Group one is {1,2,4,7} and group two is {0,3,5,6}. In the first pass group one holds P and group two holds Q; in the second pass the patterns are exchanged. In each pass every register is read 8 times. Fail is 0 when the final signature equals the expected input.
- R6: Fail is 1 with done when the final signature differs from the expected input. Fail holds until the next start.
- R7: After a test, registers 1, 2, 4 and 7 hold 32'hAAAA_AAAA and registers 0, 3, 5 and 6 hold 32'h5555_5555.
- R8: While busy, the functional write inputs have no effect on the storage or on the signature.
- R9: A start pulse while busy is ignored: the run neither restarts nor lengthens.
- R10: During a test, no read cycle begins before at least three cycles without any write have passed since the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fn_wa_en | input | 1 | Lane A functional write enable |
| fn_wa_addr | input | 3 | Lane A functional write address |
| fn_wa_data | input | DW | Lane A functional write data |
| fn_wb_en | input | 1 | Lane B functional write enable |
| fn_wb_addr | input | 3 | Lane B functional write address |
| fn_wb_data | input | DW | Lane B functional write data |
| fn_ra1_addr | input | 3 | Lane A first read address |
| fn_ra2_addr | input | 3 | Lane A second read address |
| fn_rb1_addr | input | 3 | Lane B first read address |
| fn_rb2_addr | input | 3 | Lane B second read address |
| ra1_data | output | DW | Lane A first read data |
| ra2_data | output | DW | Lane A second read data |
| rb1_data | output | DW | Lane B first read data |
| rb2_data | output | DW | Lane B second read data |
| test_start | input | 1 | Start pulse for the self-test |
| test_expect | input | DW | Expected final signature |
| test_busy | output | 1 | Self-test running |
| test_done | output | 1 | One-cycle end-of-test pulse |
| test_fail | output | 1 | Signature mismatch flag |
| test_sig | output | DW | Running signature |

## Verification
Random normal-mode traffic on both lanes, checked against a bench model of the storage, shows that every decoder and multiplexer routes its own address. A directed same-address dual write isolates the lane priority. Full test runs are done under three conditions: with the correct expected signature, with a wrong one, and with random functional writes and a stray start injected while busy. These separate a correct pass from a detected mismatch and from leakage of functional inputs into the test. A run that starts from random register contents shows that the final state and signature depend only on the test schedule.

// File: rtl/regfile_bist.sv
module regfile_bist #(
  parameter int DW = 32,
  parameter int GAP_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fn_wa_en,
  input  logic [2:0]    fn_wa_addr,
  input  logic [DW-1:0] fn_wa_data,
  input  logic          fn_wb_en,
  input  logic [2:0]    fn_wb_addr,
  input  logic [DW-1:0] fn_wb_data,
  input  logic [2:0]    fn_ra1_addr,
  input  logic [2:0]    fn_ra2_addr,
  input  logic [2:0]    fn_rb1_addr,
  input  logic [2:0]    fn_rb2_addr,
  output logic [DW-1:0] ra1_data,
  output logic [DW-1:0] ra2_data,
  output logic [DW-1:0] rb1_data,
  output logic [DW-1:0] rb2_data,
  input  logic          test_start,
  input  logic [DW-1:0] test_expect,
  output logic          test_busy,
  output logic          test_done,
  output logic          test_fail,
  output logic [DW-1:0] test_sig
);
  localparam int NREG = 8;
  localparam int CW = 4;
  localparam logic [DW-1:0] PAT_P = {(DW/2){2'b01}};
  localparam logic [DW-1:0] PAT_Q = ~PAT_P;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_GAP, S_RD} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic           phase, inv;
  logic [DW-1:0]  sig;
  logic           done_q, fail_q;
  logic [DW-1:0]  regs [NREG];

  function automatic logic [2:0] sched_reg(input logic set, input logic [1:0] k);
    case ({set, k})
      3'd0: return 3'd1;
      3'd1: return 3'd2;
      3'd2: return 3'd0;
      3'd3: return 3'd3;
      3'd4: return 3'd4;
      3'd5: return 3'd7;
      3'd6: return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  wire tm = (st != S_IDLE);
  wire [DW-1:0] pat_g1 = inv ? PAT_Q : PAT_P;
  wire [DW-1:0] t_wdata = cnt[1] ? ~pat_g1 : pat_g1;

  wire          wa_en   = tm ? (st == S_WR) : fn_wa_en;
  wire          wb_en   = tm ? (st == S_WR) : fn_wb_en;
  wire [2:0]    wa_addr = tm ? sched_reg(phase, cnt[1:0])  : fn_wa_addr;
  wire [2:0]    wb_addr = tm ? sched_reg(~phase, cnt[1:0]) : fn_wb_addr;
  wire [DW-1:0] wa_data = tm ? t_wdata : fn_wa_data;
  wire [DW-1:0] wb_data = tm ? t_wdata : fn_wb_data;
  wire [2:0]    ra1_addr = tm ? cnt[2:0] : fn_ra1_addr;
  wire [2:0]    ra2_addr = tm ? cnt[2:0] : fn_ra2_addr;
  wire [2:0]    rb1_addr = tm ? cnt[2:0] : fn_rb1_addr;
  wire [2:0]    rb2_addr = tm ? cnt[2:0] : fn_rb2_addr;

  assign ra1_data = regs[ra1_addr];
  assign ra2_data = regs[ra2_addr];
  assign rb1_data = regs[rb1_addr];
  assign rb2_data = regs[rb2_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (wa_en) regs[wa_addr] <= wa_data;
      if (wb_en) regs[wb_addr] <= wb_data;
    end
  end

  wire [DW-1:0] sig_nxt = sig + (cnt[3] ? (ra2_data + rb2_data) : (ra1_data + rb1_data));
  wire last_rd = (st == S_RD) && (cnt == CW'(15));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; phase <= 1'b0; inv <= 1'b0;
      sig <= '0; done_q <= 1'b0; fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (test_start) begin
          st <= S_WR; cnt <= '0; phase <= 1'b0; inv <= 1'b0;
          sig <= '0; fail_q <= 1'b0;
        end
        S_WR: begin
          if (cnt == CW'(3)) begin st <= S_GAP; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          if (cnt == CW'(GAP_CYCLES - 1)) begin st <= S_RD; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        default: begin
          sig <= sig_nxt;
          if (last_rd) begin
            cnt <= '0;
            if (phase && inv) begin
              st <= S_IDLE; done_q <= 1'b1; fail_q <= (sig_nxt != test_expect);
            end else begin
              st <= S_WR; phase <= ~phase;
              if (phase) inv <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  assign test_busy = tm;
  assign test_done = done_q;
  assign test_fail = fail_q;
  assign test_sig  = sig;

  logic [7:0] quiet;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet <= 8'd0;
    else if (wa_en || wb_en) quiet <= 8'd0;
    else if (quiet != 8'hFF) quiet <= quiet + 8'd1;
  end

  a_r10_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && cnt == '0) |-> quiet >= 8'd3);

  a_r3_lane_b_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en && wa_addr == wb_addr) |=> regs[$past(wb_addr)] == $past(wb_data));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (!tm && fn_wa_en && !(fn_wb_en && fn_wb_addr == fn_wa_addr))
      |=> regs[$past(fn_wa_addr)] == $past(fn_wa_data));

  a_r4_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_busy) |-> test_done);

  a_r5_sig_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_busy) |-> test_sig == '0);
endmodule

// File: tb/tb_regfile_bist.sv
module tb_regfile_bist;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic fn_wa_en = 0, fn_wb_en = 0;
  logic [2:0] fn_wa_addr = 0, fn_wb_addr = 0;
  logic [DW-1:0] fn_wa_data = 0, fn_wb_data = 0;
  logic [2:0] fn_ra1_addr = 0, fn_ra2_addr = 0, fn_rb1_addr = 0, fn_rb2_addr = 0;
  logic [DW-1:0] ra1_data, ra2_data, rb1_data, rb2_data;
  logic test_start = 0;
  logic [DW-1:0] test_expect = 0;
  logic test_busy, test_done, test_fail;
  logic [DW-1:0] test_sig;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_bist dut (.*);

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_sig();
    logic [DW-1:0] s = '0;
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 8; r++) begin
        logic g1 = (r == 1 || r == 2 || r == 4 || r == 7);
        logic [DW-1:0] pp = (p == 0) ? 32'h5555_5555 : 32'hAAAA_AAAA;
        s = s + 32'd8 * (g1 ? pp : ~pp);
      end
    return s;
  endfunction

  function automatic logic [DW-1:0] final_val(input int r);
    return (r == 1 || r == 2 || r == 4 || r == 7) ? 32'hAAAA_AAAA : 32'h5555_5555;
  endfunction

  task automatic read_all(input string tag, input bit use_final);
    for (int r = 0; r < 8; r++) begin
      fn_ra1_addr = 3'(r); fn_ra2_addr = 3'(r); fn_rb1_addr = 3'(r); fn_rb2_addr = 3'(r);
      #1;
      chk({tag, " ra1"}, ra1_data, use_final ? final_val(r) : model[r]);
      chk({tag, " ra2"}, ra2_data, use_final ? final_val(r) : model[r]);
      chk({tag, " rb1"}, rb1_data, use_final ? final_val(r) : model[r]);
      chk({tag, " rb2"}, rb2_data, use_final ? final_val(r) : model[r]);
    end
  endtask

  task automatic run_test(input logic [DW-1:0] expv, input bit noise, input logic exp_fail,
                          input string tag);
    int cyc = 0;
    test_expect = expv;
    @(negedge clk) test_start = 1;
    @(negedge clk) test_start = 0;
    chk({tag, " R4 busy after start"}, test_busy, 1);
    while (test_busy && cyc < 300) begin
      cyc++;
      if (noise) begin
        fn_wa_en = 1; fn_wb_en = 1;
        fn_wa_addr = 3'($urandom); fn_wb_addr = 3'($urandom);
        fn_wa_data = $urandom; fn_wb_data = $urandom;
        test_start = (cyc == 40);
      end
      @(negedge clk);
    end
    fn_wa_en = 0; fn_wb_en = 0; test_start = 0;
    chk({tag, " R4 R9 busy length"}, cyc, 92);
    chk({tag, " R4 done pulse"}, test_done, 1);
    chk({tag, " R5 signature"}, test_sig, exp_sig());
    chk({tag, exp_fail ? " R6 fail set" : " R5 pass"}, test_fail, exp_fail);
    @(negedge clk);
    chk({tag, " R4 done one cycle"}, test_done, 0);
    chk({tag, " R6 fail held"}, test_fail, exp_fail);
    for (int r = 0; r < 8; r++) model[r] = final_val(r);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) model[r] = '0;
    #(CLK_PERIOD*2);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk("R1 busy", test_busy, 0);
    chk("R1 done", test_done, 0);
    chk("R1 fail", test_fail, 0);
    chk("R1 sig", test_sig, 0);
    read_all("R1 reset regs", 0);

    // R2 random normal-mode traffic
    for (int it = 0; it < 300; it++) begin
      @(negedge clk);
      fn_wa_en = 1'($urandom); fn_wb_en = 1'($urandom);
      fn_wa_addr = 3'($urandom); fn_wb_addr = 3'($urandom);
      fn_wa_data = $urandom; fn_wb_data = $urandom;
      @(posedge clk);
      if (fn_wa_en) model[fn_wa_addr] = fn_wa_data;
      if (fn_wb_en) model[fn_wb_addr] = fn_wb_data;
      @(negedge clk);
      fn_wa_en = 0; fn_wb_en = 0;
      fn_ra1_addr = 3'($urandom); fn_ra2_addr = 3'($urandom);
      fn_rb1_addr = 3'($urandom); fn_rb2_addr = 3'($urandom);
      #1;
      chk("R2 ra1", ra1_data, model[fn_ra1_addr]);
      chk("R2 ra2", ra2_data, model[fn_ra2_addr]);
      chk("R2 rb1", rb1_data, model[fn_rb1_addr]);
      chk("R2 rb2", rb2_data, model[fn_rb2_addr]);
    end

    // R3 same-address collision
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      fn_wa_en = 1; fn_wb_en = 1; fn_wa_addr = 3'(r); fn_wb_addr = 3'(r);
      fn_wa_data = 32'h1111_0000 + r; fn_wb_data = 32'h2222_0000 + r;
      @(negedge clk);
      fn_wa_en = 0; fn_wb_en = 0;
      model[r] = 32'h2222_0000 + r;
      fn_ra1_addr = 3'(r); #1;
      chk("R3 lane B wins", ra1_data, 32'h2222_0000 + r);
    end

    run_test(exp_sig(), 0, 0, "run1");
    read_all("R7 final contents", 1);

    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      fn_wa_en = 1; fn_wa_addr = 3'(r); fn_wa_data = $urandom;
    end
    @(negedge clk) fn_wa_en = 0;
    run_test(exp_sig(), 1, 0, "run2 R8 noise");
    read_all("R8 R7 contents after noise", 1);

    run_test(exp_sig() ^ 32'h0000_0100, 0, 1, "run3");
    read_all("R7 contents run3", 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule